// File: doc/BRIEF.md
# I2C Real-Time Counter Register Slave

This block is the serial front end of a small real-time counter device. It sits on a two-wire I2C bus as a slave. It recognises its own 7-bit device address, takes a register pointer from the first byte the master writes, and then moves bytes to or from six byte-wide registers. The pointer steps forward after every data byte and returns to zero after the last register, so a single transaction can sweep the whole map. It runs until the master sends STOP.

The register map has six locations:

| Address | Contents |
|---------|----------|
| 0 to 3 | A 32-bit counter, least significant byte first |
| 4 | Control byte, whose top bit disables the oscillator |
| 5 | Charger configuration byte, split into a select nibble and two 2-bit selects |

Toward the device core the block does three things. It takes the live counter value as an input. It issues a single-cycle commit strobe with a full 32-bit value when the counter has been written. It drives the decoded configuration fields as outputs. A power-fail input from the supply monitor shuts out the bus entirely, and SDA is only ever pulled low: the block never drives it high.

Top module: `i2c_rtc_regs`

## Requirements
- R1: After reset, `sda_oe_o` is 0, `osc_dis_o` is 0, all charger fields are 0 and `cnt_wr_o` stays low; `sda_oe_o` high means SDA is pulled low, and it is never used to drive a high level.
- R2: A byte after START whose upper seven bits equal `DEV_ADDR` is acknowledged by pulling SDA low during the ninth clock; any other address is left unacknowledged and the rest of that transaction is ignored.
- R3: Writing register 4 sets `osc_dis_o` from data bit 7; reading register 4 returns bit 7 as stored and bits 6:0 as zero.
- R4: Writing register 5 drives `chg_sel_o` from bits 7:4, `diode_sel_o` from bits 3:2 and `res_sel_o` from bits 1:0, and reading it returns the stored byte.
- R5: The pointer advances after each data byte written or read, and it steps from 5 to 0.
- R6: Writes to counter bytes 0 to 3 are staged: `cnt_wr_o` pulses exactly once, at STOP, carrying all 32 staged bits, with byte 0 as bits 7:0 and byte 3 as bits 31:24.
- R7: The counter is sampled into a snapshot at START, so bytes read later in that transaction show the value from START even if `cnt_i` changes between byte reads.
- R8: A read sequence continues through the pointer wrap, returning register 4, then 5, then counter byte 0.
- R9: While `inhibit_i` is high the slave does not acknowledge its address, never pulls SDA low, and changes no register; a pending counter write is discarded.
- R10: A pointer byte of 6 or more sets the pointer to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; bus lines are oversampled |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | High pulls SDA low |
| inhibit_i | input | 1 | Power-fail flag; high blocks all access |
| cnt_i | input | 32 | Live counter value |
| cnt_wr_o | output | 1 | One-cycle commit strobe for the counter |
| cnt_wdata_o | output | 32 | Counter value to load on `cnt_wr_o` |
| osc_dis_o | output | 1 | Oscillator disable bit |
| chg_sel_o | output | 4 | Charger select field |
| diode_sel_o | output | 2 | Diode select field |
| res_sel_o | output | 2 | Resistor select field |

## Verification
The bench builds the block with `DEV_ADDR = 7'h51` rather than the default. This shows that address matching follows the parameter and is not tied to one constant. It also uses `SYNC_STAGES = 3`, which lengthens the delay from a bus edge to the state machine. With that setting, every ACK and read bit must still settle within a quarter bus period of eight clocks. At these values, the wrap from register 5 to 0, repeated START and a counter change between byte reads can all be reached in a few short transactions.

// File: rtl/i2c_rtc_pkg.sv
package i2c_rtc_pkg;
  localparam int BYTE_BITS = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RDAT_ACK
  } bus_st_e;
endpackage

// File: rtl/i2c_rtc_edge.sv
module i2c_rtc_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  // stage[g] = {scl, sda}
  logic [SYNC_STAGES-1:0][1:0] stg_q;
  logic [1:0]                  prev_q;
  logic                        scl_s, sda_s;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[g] <= 2'b11;
        else         stg_q[g] <= {scl_i, sda_i};
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[g] <= 2'b11;
        else         stg_q[g] <= stg_q[g-1];
    end
  end

  assign scl_s = stg_q[SYNC_STAGES-1][1];
  assign sda_s = stg_q[SYNC_STAGES-1][0];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 2'b11;
    else         prev_q <= {scl_s, sda_s};

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~prev_q[1];
  assign scl_fall_o = ~scl_s & prev_q[1];
  assign start_o    = scl_s & prev_q[1] & prev_q[0] & ~sda_s;
  assign stop_o     = scl_s & prev_q[1] & ~prev_q[0] & sda_s;
endmodule

// File: rtl/i2c_rtc_bus.sv
module i2c_rtc_bus
  import i2c_rtc_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h68
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sda_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       inhibit_i,
  input  logic [7:0] rd_byte_i,
  output logic       sda_oe_o,
  output logic       sta_o,
  output logic       sto_o,
  output logic       ptr_wr_o,
  output logic       dat_wr_o,
  output logic       rd_adv_o,
  output logic [7:0] rx_byte_o
);
  bus_st_e    state_q;
  logic [3:0] bit_q;
  logic [7:0] sh_q;
  logic       oe_q, rw_q, mack_q;
  logic       sta_q, sto_q, ptr_q, dat_q, adv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      sh_q    <= '0;
      oe_q    <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      sta_q   <= 1'b0;
      sto_q   <= 1'b0;
      ptr_q   <= 1'b0;
      dat_q   <= 1'b0;
      adv_q   <= 1'b0;
    end else begin
      sta_q <= 1'b0;
      sto_q <= 1'b0;
      ptr_q <= 1'b0;
      dat_q <= 1'b0;
      adv_q <= 1'b0;
      if (inhibit_i) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else if (start_i) begin
        state_q <= ST_ADDR;
        bit_q   <= '0;
        oe_q    <= 1'b0;
        sta_q   <= 1'b1;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
        sto_q   <= 1'b1;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_PTR, ST_WDAT: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[6:0], sda_i};
              bit_q <= bit_q + 4'd1;
            end else if (scl_fall_i && bit_q == 4'(BYTE_BITS)) begin
              bit_q <= '0;
              if (state_q == ST_ADDR) begin
                if (sh_q[7:1] == DEV_ADDR) begin
                  oe_q    <= 1'b1;
                  rw_q    <= sh_q[0];
                  state_q <= ST_ADDR_ACK;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else if (state_q == ST_PTR) begin
                oe_q    <= 1'b1;
                ptr_q   <= 1'b1;
                state_q <= ST_PTR_ACK;
              end else begin
                oe_q    <= 1'b1;
                dat_q   <= 1'b1;
                state_q <= ST_WDAT_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall_i) begin
              if (rw_q) begin
                sh_q    <= rd_byte_i;
                oe_q    <= ~rd_byte_i[7];
                adv_q   <= 1'b1;
                state_q <= ST_RDAT;
              end else begin
                oe_q    <= 1'b0;
                state_q <= ST_PTR;
              end
            end
          end
          ST_PTR_ACK, ST_WDAT_ACK: begin
            if (scl_fall_i) begin
              oe_q    <= 1'b0;
              state_q <= ST_WDAT;
            end
          end
          ST_RDAT: begin
            if (scl_fall_i) begin
              if (bit_q == 4'(BYTE_BITS - 1)) begin
                oe_q    <= 1'b0;
                bit_q   <= '0;
                state_q <= ST_RDAT_ACK;
              end else begin
                sh_q  <= {sh_q[6:0], 1'b0};
                oe_q  <= ~sh_q[6];
                bit_q <= bit_q + 4'd1;
              end
            end
          end
          ST_RDAT_ACK: begin
            if (scl_rise_i) begin
              mack_q <= ~sda_i;
            end else if (scl_fall_i) begin
              if (mack_q) begin
                sh_q    <= rd_byte_i;
                oe_q    <= ~rd_byte_i[7];
                adv_q   <= 1'b1;
                state_q <= ST_RDAT;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o  = oe_q;
  assign sta_o     = sta_q;
  assign sto_o     = sto_q;
  assign ptr_wr_o  = ptr_q;
  assign dat_wr_o  = dat_q;
  assign rd_adv_o  = adv_q;
  assign rx_byte_o = sh_q;

  AST_INHIBIT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_i |=> !sda_oe_o); // R9
  AST_ADDR_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ADDR_ACK && $rose(oe_q)) |-> ($past(sh_q[7:1]) == DEV_ADDR)); // R2
  AST_ACK_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RDAT_ACK) |-> !sda_oe_o); // R1
endmodule

// File: rtl/i2c_rtc_regfile.sv
module i2c_rtc_regfile #(
  parameter int CNT_BYTES = 4,
  localparam int CNT_W    = 8 * CNT_BYTES,
  localparam int NUM_REGS = CNT_BYTES + 2,
  localparam int PTR_W    = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inhibit_i,
  input  logic             sta_i,
  input  logic             sto_i,
  input  logic             ptr_wr_i,
  input  logic             dat_wr_i,
  input  logic             rd_adv_i,
  input  logic [7:0]       rx_byte_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [7:0]       rd_byte_o,
  output logic             cnt_wr_o,
  output logic [CNT_W-1:0] cnt_wdata_o,
  output logic             osc_dis_o,
  output logic [7:0]       chg_o
);
  localparam int REG_CTRL = CNT_BYTES;
  localparam int REG_CHG  = CNT_BYTES + 1;

  logic [PTR_W-1:0] ptr_q, ptr_nxt;
  logic [CNT_W-1:0] snap_q, wdat_q;
  logic             dirty_q, osc_q, cwr_q;
  logic [7:0]       chg_q;

  assign ptr_nxt = (ptr_q == PTR_W'(REG_CHG)) ? '0 : ptr_q + PTR_W'(1);

  always_comb begin
    rd_byte_o = 8'h00;
    for (int i = 0; i < CNT_BYTES; i++)
      if (ptr_q == PTR_W'(i)) rd_byte_o = snap_q[8*i +: 8];
    if (ptr_q == PTR_W'(REG_CTRL)) rd_byte_o = {osc_q, 7'b0};
    if (ptr_q == PTR_W'(REG_CHG))  rd_byte_o = chg_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      snap_q  <= '0;
      wdat_q  <= '0;
      dirty_q <= 1'b0;
      osc_q   <= 1'b0;
      chg_q   <= '0;
      cwr_q   <= 1'b0;
    end else begin
      cwr_q <= 1'b0;
      if (inhibit_i) begin
        dirty_q <= 1'b0;
      end else if (sta_i) begin
        // keep staged bytes across a repeated START
        if (!dirty_q) snap_q <= cnt_i;
      end else if (sto_i) begin
        if (dirty_q) begin
          cwr_q   <= 1'b1;
          wdat_q  <= snap_q;
          dirty_q <= 1'b0;
        end
      end else if (ptr_wr_i) begin
        ptr_q <= (rx_byte_i < 8'(NUM_REGS)) ? rx_byte_i[PTR_W-1:0] : '0;
      end else if (dat_wr_i) begin
        for (int i = 0; i < CNT_BYTES; i++)
          if (ptr_q == PTR_W'(i)) begin
            snap_q[8*i +: 8] <= rx_byte_i;
            dirty_q          <= 1'b1;
          end
        if (ptr_q == PTR_W'(REG_CTRL)) osc_q <= rx_byte_i[7];
        if (ptr_q == PTR_W'(REG_CHG))  chg_q <= rx_byte_i;
        ptr_q <= ptr_nxt;
      end else if (rd_adv_i) begin
        ptr_q <= ptr_nxt;
      end
    end
  end

  assign cnt_wr_o    = cwr_q;
  assign cnt_wdata_o = wdat_q;
  assign osc_dis_o   = osc_q;
  assign chg_o       = chg_q;

  AST_PTR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_adv_i || dat_wr_i) && !inhibit_i && ptr_q == PTR_W'(REG_CHG)) |=> (ptr_q == '0)); // R5
  AST_COMMIT_AT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr_o |-> $past(sto_i)); // R6
  AST_PTR_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_wr_i && !inhibit_i && rx_byte_i >= 8'(NUM_REGS)) |=> (ptr_q == '0)); // R10
endmodule

// File: rtl/i2c_rtc_regs.sv
module i2c_rtc_regs #(
  parameter logic [6:0] DEV_ADDR    = 7'h68,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe_o,
  input  logic        inhibit_i,
  input  logic [31:0] cnt_i,
  output logic        cnt_wr_o,
  output logic [31:0] cnt_wdata_o,
  output logic        osc_dis_o,
  output logic [3:0]  chg_sel_o,
  output logic [1:0]  diode_sel_o,
  output logic [1:0]  res_sel_o
);
  logic       sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic       sta, sto, ptr_wr, dat_wr, rd_adv;
  logic [7:0] rx_byte, rd_byte, chg;

  i2c_rtc_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_ev), .stop_o(stop_ev)
  );

  i2c_rtc_bus #(.DEV_ADDR(DEV_ADDR)) u_bus (
    .clk_i, .rst_ni, .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_ev), .stop_i(stop_ev), .inhibit_i,
    .rd_byte_i(rd_byte), .sda_oe_o,
    .sta_o(sta), .sto_o(sto), .ptr_wr_o(ptr_wr), .dat_wr_o(dat_wr),
    .rd_adv_o(rd_adv), .rx_byte_o(rx_byte)
  );

  i2c_rtc_regfile #(.CNT_BYTES(4)) u_regs (
    .clk_i, .rst_ni, .inhibit_i,
    .sta_i(sta), .sto_i(sto), .ptr_wr_i(ptr_wr), .dat_wr_i(dat_wr),
    .rd_adv_i(rd_adv), .rx_byte_i(rx_byte), .cnt_i,
    .rd_byte_o(rd_byte), .cnt_wr_o, .cnt_wdata_o, .osc_dis_o, .chg_o(chg)
  );

  assign chg_sel_o   = chg[7:4];
  assign diode_sel_o = chg[3:2];
  assign res_sel_o   = chg[1:0];

  AST_NO_WRITE_INHIBIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(inhibit_i) |-> !(dat_wr || ptr_wr)); // R9
  AST_NO_COMMIT_INHIBIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(inhibit_i) && inhibit_i) |-> !cnt_wr_o); // R9
endmodule

// File: tb/sim_i2c_rtc_regs.sv
module sim_i2c_rtc_regs;
  localparam logic [6:0] DEV = 7'h51;
  localparam int Q = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        scl_drv = 1'b1, sda_drv = 1'b1, inhibit = 1'b0;
  logic        sda_oe, sda_line;
  logic [31:0] cnt_live = 32'h0;
  logic        cnt_wr, osc_dis;
  logic [31:0] cnt_wdata;
  logic [3:0]  chg_sel;
  logic [1:0]  diode_sel, res_sel;

  int checks = 0, errors = 0, n_commit = 0, oe_inh = 0;
  logic [31:0] last_commit = '0;
  logic done = 1'b0;

  always #4 clk = ~clk;
  assign sda_line = sda_drv & ~sda_oe;

  i2c_rtc_regs #(.DEV_ADDR(DEV), .SYNC_STAGES(3)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .inhibit_i(inhibit), .cnt_i(cnt_live),
    .cnt_wr_o(cnt_wr), .cnt_wdata_o(cnt_wdata), .osc_dis_o(osc_dis),
    .chg_sel_o(chg_sel), .diode_sel_o(diode_sel), .res_sel_o(res_sel)
  );

  always @(posedge clk) begin
    if (cnt_wr) begin
      n_commit    <= n_commit + 1;
      last_commit <= cnt_wdata;
    end
    if (inhibit && sda_oe) oe_inh <= oe_inh + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_drv = 1'b1; wq(Q);
    scl_drv = 1'b1; wq(Q);
    sda_drv = 1'b0; wq(Q);
    scl_drv = 1'b0; wq(Q);
  endtask

  task automatic bus_stop;
    sda_drv = 1'b0; wq(Q);
    scl_drv = 1'b1; wq(Q);
    sda_drv = 1'b1; wq(2*Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack_n);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; wq(Q);
      scl_drv = 1'b1; wq(2*Q);
      scl_drv = 1'b0; wq(Q);
    end
    sda_drv = 1'b1; wq(Q);
    scl_drv = 1'b1; wq(Q);
    ack_n = sda_line; wq(Q);
    scl_drv = 1'b0; wq(Q);
  endtask

  task automatic get_byte(input logic nack, output logic [7:0] d);
    sda_drv = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wq(Q);
      scl_drv = 1'b1; wq(Q);
      d = {d[6:0], sda_line}; wq(Q);
      scl_drv = 1'b0;
    end
    wq(Q);
    sda_drv = nack; wq(Q);
    scl_drv = 1'b1; wq(2*Q);
    scl_drv = 1'b0; wq(Q);
    sda_drv = 1'b1;
  endtask

  task automatic set_ptr_then_read(input logic [7:0] ptr);
    logic a;
    bus_start;
    put_byte({DEV, 1'b0}, a);
    put_byte(ptr, a);
    bus_start;
    put_byte({DEV, 1'b1}, a);
  endtask

  task automatic t_reset;
    chk(sda_oe == 1'b0, "R1 sda_oe", 32'(sda_oe), 0);
    chk(osc_dis == 1'b0, "R1 osc_dis", 32'(osc_dis), 0);
    chk({chg_sel, diode_sel, res_sel} == 8'h00, "R1 charger", {24'h0, chg_sel, diode_sel, res_sel}, 0);
    chk(n_commit == 0, "R1 no commit", 32'(n_commit), 0);
  endtask

  task automatic t_addr;
    logic a;
    bus_start;
    put_byte({7'h50, 1'b0}, a);
    chk(a == 1'b1, "R2 foreign address nack", 32'(a), 1);
    put_byte(8'h04, a);
    chk(a == 1'b1, "R2 ignored after nack", 32'(a), 1);
    bus_stop;
    bus_start;
    put_byte({DEV, 1'b0}, a);
    chk(a == 1'b0, "R2 own address ack", 32'(a), 0);
    bus_stop;
  endtask

  task automatic t_ctrl;
    logic a; logic [7:0] d;
    bus_start;
    put_byte({DEV, 1'b0}, a);
    put_byte(8'h04, a);
    put_byte(8'hFF, a);
    bus_stop;
    chk(osc_dis == 1'b1, "R3 osc_dis set", 32'(osc_dis), 1);
    set_ptr_then_read(8'h04);
    get_byte(1'b1, d);
    bus_stop;
    chk(d == 8'h80, "R3 ctrl readback", 32'(d), 32'h80);
    bus_start;
    put_byte({DEV, 1'b0}, a);
    put_byte(8'h04, a);
    put_byte(8'h7F, a);
    bus_stop;
    chk(osc_dis == 1'b0, "R3 osc_dis clear", 32'(osc_dis), 0);
  endtask

  task automatic t_chg;
    logic a; logic [7:0] d;
    bus_start;
    put_byte({DEV, 1'b0}, a);
    put_byte(8'h05, a);
    put_byte(8'hA6, a);
    bus_stop;
    chk(chg_sel == 4'hA, "R4 chg_sel", 32'(chg_sel), 32'hA);
    chk(diode_sel == 2'b01, "R4 diode_sel", 32'(diode_sel), 1);
    chk(res_sel == 2'b10, "R4 res_sel", 32'(res_sel), 2);
    set_ptr_then_read(8'h05);
    get_byte(1'b1, d);
    bus_stop;
    chk(d == 8'hA6, "R4 chg readback", 32'(d), 32'hA6);
  endtask

  task automatic t_wrap_write;
    logic a; int base;
    base = n_commit;
    bus_start;
    put_byte({DEV, 1'b0}, a);
    put_byte(8'h05, a);
    put_byte(8'h3C, a);
    put_byte(8'h11, a);
    put_byte(8'h22, a);
    put_byte(8'h33, a);
    put_byte(8'h44, a);
    chk(a == 1'b0, "R5 ack after wrap", 32'(a), 0);
    chk(n_commit == base, "R6 no commit before stop", 32'(n_commit), 32'(base));
    bus_stop;
    chk(chg_sel == 4'h3 && diode_sel == 2'b11 && res_sel == 2'b00, "R5 reg5 before wrap",
        {24'h0, chg_sel, diode_sel, res_sel}, 32'h3C);
    chk(n_commit == base + 1, "R6 single commit", 32'(n_commit), 32'(base + 1));
    chk(last_commit == 32'h44332211, "R6 commit value", last_commit, 32'h44332211);
  endtask

  task automatic t_shadow;
    logic [7:0] d0, d1, d2, d3;
    cnt_live = 32'h0A0B0C0D;
    set_ptr_then_read(8'h00);
    get_byte(1'b0, d0);
    cnt_live = 32'hFFFFFFFF;
    get_byte(1'b0, d1);
    cnt_live = 32'h00000000;
    get_byte(1'b0, d2);
    get_byte(1'b1, d3);
    bus_stop;
    chk({d3, d2, d1, d0} == 32'h0A0B0C0D, "R7 snapshot read", {d3, d2, d1, d0}, 32'h0A0B0C0D);
  endtask

  task automatic t_read_wrap;
    logic [7:0] d0, d1, d2;
    cnt_live = 32'h55AA66E7;
    set_ptr_then_read(8'h04);
    get_byte(1'b0, d0);
    get_byte(1'b0, d1);
    get_byte(1'b1, d2);
    bus_stop;
    chk(d0 == 8'h00, "R8 reg4 first", 32'(d0), 0);
    chk(d1 == 8'h3C, "R8 reg5 second", 32'(d1), 32'h3C);
    chk(d2 == 8'hE7, "R8 wrap to byte0", 32'(d2), 32'hE7);
  endtask

  task automatic t_inhibit;
    logic a; int base;
    base = n_commit;
    inhibit = 1'b1;
    wq(4);
    bus_start;
    put_byte({DEV, 1'b0}, a);
    chk(a == 1'b1, "R9 nack when inhibited", 32'(a), 1);
    put_byte(8'h04, a);
    put_byte(8'h80, a);
    chk(a == 1'b1, "R9 data ignored", 32'(a), 1);
    bus_stop;
    inhibit = 1'b0;
    wq(4);
    chk(osc_dis == 1'b0, "R9 ctrl unchanged", 32'(osc_dis), 0);
    chk(oe_inh == 0, "R9 sda never pulled", 32'(oe_inh), 0);
    chk(n_commit == base, "R9 no commit", 32'(n_commit), 32'(base));
    // staged counter write dropped by a power-fail before STOP
    bus_start;
    put_byte({DEV, 1'b0}, a);
    put_byte(8'h00, a);
    put_byte(8'h99, a);
    inhibit = 1'b1;
    wq(4);
    bus_stop;
    inhibit = 1'b0;
    wq(4);
    bus_start;
    bus_stop;
    chk(n_commit == base, "R9 pending write discarded", 32'(n_commit), 32'(base));
  endtask

  task automatic t_ptr_range;
    logic [7:0] d;
    cnt_live = 32'h12345678;
    set_ptr_then_read(8'h09);
    get_byte(1'b1, d);
    bus_stop;
    chk(d == 8'h78, "R10 out-of-range pointer", 32'(d), 32'h78);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset;
    t_addr;
    t_ctrl;
    t_chg;
    t_wrap_write;
    t_shadow;
    t_read_wrap;
    t_inhibit;
    t_ptr_range;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog act=%0d exp=0", checks);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule